// File: doc/BRIEF.md
# 22 kHz Tone Gating Controller

This block produces the digital tone level that a satellite-supply regulator superimposes on its output rail for dish-control signalling. It holds its own square-wave generator, clocked from the system clock, and chooses among five ways of forming the tone. The choice depends on an external modulation pin and three control bits: a host-control enable, an internal-source select and a gate. A one-bit classifier tells apart a pin that carries a ready-made 22 kHz burst from one that carries a slow envelope.

The block also passes on a two-bit placement code. This code tells the analog stage whether the tone sits above the nominal voltage, straddles it, or sits below it. Both outputs are registered. The external pin passes through a synchroniser first, so it reaches the tone output three clock edges after it changes. A control bit reaches the output one edge after it changes.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `tone_o` is 0 and `place_o` is 2'b00, whatever the inputs are.
- R2: The internal generator makes a square wave with a half period of HALF_CYC = CLK_HZ/(2*TONE_HZ) cycles. High and low halves are the same length, and every run starts with a high half.
- R3: The generator starts at the beginning of a high half whenever it is enabled from idle. When its enable is withdrawn, it finishes the half period in progress and then goes quiet. This also holds when the enable falls on the very edge where a half expires.
- R4: With host control off (`reg_host_en`=0), a pin that has toggled within the last WINDOW_US microseconds counts as a burst. The pin level is then copied to `tone_o` three cycles after it changes.
- R5: With host control off, a pin that has been steady high for longer than the window counts as an envelope and switches on the internal wave. A pin held low gives a low `tone_o`.
- R6: With `reg_host_en`=1 and `reg_src_int`=0, `tone_o` is the pin level ANDed with `reg_gate`. With `reg_gate`=0 the output stays 0 whatever the pin does.
- R7: With `reg_host_en`=1, `reg_src_int`=1 and the pin low, `reg_gate` switches the internal wave on and off.
- R8: With `reg_host_en`=1, `reg_src_int`=1 and `reg_gate`=1, a high pin arms envelope operation. When the pin later falls, the wave goes on until it has completed a high half, so the last half it emits is high.
- R9: `place_o` follows `reg_place` one cycle later. The codes are 2'b00 = tone above the rail, 2'b01 = centred on the rail and 2'b10 = below the rail. Code 2'b11 is output as 2'b00.
- R10: A change on a control bit reaches `tone_o` one cycle later. A change on `extm_i` reaches `tone_o` SYNC_STAGES+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| extm_i | input | 1 | External modulation pin, asynchronous |
| reg_host_en | input | 1 | 1: control bits govern the tone; 0: the pin governs it |
| reg_src_int | input | 1 | In host mode, 1 selects the internal generator and 0 selects the pin |
| reg_gate | input | 1 | Tone gate in host mode |
| reg_place | input | 2 | Requested tone placement code |
| tone_o | output | 1 | Registered tone level |
| place_o | output | 2 | Registered placement code |

## Verification
Two events can land on the same clock edge: the gate being withdrawn, and the generator's half-period counter reaching its end. The bench provokes this by dropping `reg_gate` in the cycle just before the edge where the high half expires. It then checks that the output falls on time and stays low, with no extra half and no re-armed wave. A second case drops the pin envelope in the middle of a low half with stop-high active. The bench judges this case by the exact sample where one final high half appears and ends.

// File: rtl/tone_gate_pkg.sv
package tone_gate_pkg;

  typedef enum logic [1:0] {
    PLACE_ABOVE = 2'b00,
    PLACE_MID   = 2'b01,
    PLACE_BELOW = 2'b10
  } place_t;

  typedef enum logic [2:0] {
    SRC_PIN_BURST,
    SRC_PIN_ENV,
    SRC_EXT_GATED,
    SRC_INT_GATED,
    SRC_INT_ENV
  } src_t;

  // Unused code 11 folds onto the default placement (R9)
  function automatic logic [1:0] fold_place(input logic [1:0] code);
    return (code == 2'b11) ? PLACE_ABOVE : code;
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/tone_burst_detect.sv
module tone_burst_detect #(
  parameter int WINDOW_CYC = 25000
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic burst_o
);
  localparam int CW = $clog2(WINDOW_CYC + 1);

  logic          prev_q;
  logic          burst_q;
  logic [CW-1:0] quiet_q;
  logic          toggle;

  assign toggle  = lvl_i ^ prev_q;
  assign burst_o = burst_q | toggle;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      burst_q <= 1'b0;
      quiet_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (toggle) begin
        burst_q <= 1'b1;
        quiet_q <= '0;
      end else if (burst_q) begin
        if (quiet_q == CW'(WINDOW_CYC - 1)) burst_q <= 1'b0;
        else                                quiet_q <= quiet_q + 1'b1;
      end
    end
  end

  // R4: any edge on the pin marks it as a burst
  a_r4_edge_marks_burst: assert property (@(posedge clk) disable iff (rst)
    toggle |=> burst_q);

  // R5: a pin quiet for the whole window returns to envelope class
  a_r5_quiet_clears: assert property (@(posedge clk) disable iff (rst)
    (burst_q && !toggle && quiet_q == CW'(WINDOW_CYC - 1)) |=> !burst_q);
endmodule

// File: rtl/tone_square_gen.sv
module tone_square_gen #(
  parameter int HALF_CYC = 5681
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic stop_high_i,
  output logic tone_o,
  output logic busy_o
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic          run_q;
  logic          ph_q;
  logic [CW-1:0] cnt_q;
  logic          half_end;

  assign half_end = run_q && (cnt_q == CW'(HALF_CYC - 1));
  assign tone_o   = run_q & ph_q;
  assign busy_o   = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q <= 1'b1;
        ph_q  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (!half_end) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (en_i) begin
        ph_q <= ~ph_q;
      end else if (stop_high_i && !ph_q) begin
        ph_q <= 1'b1;
      end else begin
        run_q <= 1'b0;
        ph_q  <= 1'b0;
      end
    end
  end

  // R3: enabling from idle starts on a high half
  a_r3_restart_high: assert property (@(posedge clk) disable iff (rst)
    (!run_q && en_i) |=> tone_o);

  // R2: the level is held for the whole half period
  a_r2_half_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && !half_end) |=> (run_q && $stable(ph_q)));

  // R8: a stop-high wind-down after a low half emits one more high half
  a_r8_tail_high: assert property (@(posedge clk) disable iff (rst)
    (half_end && !en_i && stop_high_i && !ph_q) |=> tone_o);
endmodule

// File: rtl/tone_gate_ctrl.sv
module tone_gate_ctrl #(
  parameter int CLK_HZ      = 250_000_000,
  parameter int TONE_HZ     = 22_000,
  parameter int WINDOW_US   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extm_i,
  input  logic       reg_host_en,
  input  logic       reg_src_int,
  input  logic       reg_gate,
  input  logic [1:0] reg_place,
  output logic       tone_o,
  output logic [1:0] place_o
);
  import tone_gate_pkg::*;

  localparam int HALF_CYC   = CLK_HZ / (2 * TONE_HZ);
  localparam int WINDOW_CYC = int'((longint'(CLK_HZ) * longint'(WINDOW_US)) / 64'd1_000_000);

  logic extm_s;
  logic burst;
  logic gen_en;
  logic stop_high;
  logic gen_tone;
  logic gen_busy;
  logic env_q;
  logic tone_next;
  logic tone_q;
  logic [1:0] place_q;
  src_t src;

  tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (extm_i),
    .q_o (extm_s)
  );

  tone_burst_detect #(.WINDOW_CYC(WINDOW_CYC)) u_class (
    .clk     (clk),
    .rst     (rst),
    .lvl_i   (extm_s),
    .burst_o (burst)
  );

  tone_square_gen #(.HALF_CYC(HALF_CYC)) u_gen (
    .clk         (clk),
    .rst         (rst),
    .en_i        (gen_en),
    .stop_high_i (stop_high),
    .tone_o      (gen_tone),
    .busy_o      (gen_busy)
  );

  // Envelope arming for host mode with the internal source
  always_ff @(posedge clk) begin
    if (rst)                                      env_q <= 1'b0;
    else if (!(reg_host_en && reg_src_int && reg_gate)) env_q <= 1'b0;
    else if (extm_s)                              env_q <= 1'b1;
  end

  always_comb begin
    if (!reg_host_en)      src = burst ? SRC_PIN_BURST : SRC_PIN_ENV;
    else if (!reg_src_int) src = SRC_EXT_GATED;
    else if (env_q)        src = SRC_INT_ENV;
    else                   src = SRC_INT_GATED;
  end

  always_comb begin
    gen_en    = 1'b0;
    stop_high = 1'b0;
    tone_next = 1'b0;
    case (src)
      SRC_PIN_BURST: tone_next = extm_s;
      SRC_PIN_ENV: begin
        gen_en    = extm_s;
        tone_next = gen_busy ? gen_tone : extm_s;
      end
      SRC_EXT_GATED: tone_next = extm_s & reg_gate;
      SRC_INT_GATED: begin
        gen_en    = reg_gate;
        tone_next = gen_tone;
      end
      SRC_INT_ENV: begin
        gen_en    = extm_s;
        stop_high = 1'b1;
        tone_next = gen_tone;
      end
      default: tone_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_q  <= 1'b0;
      place_q <= PLACE_ABOVE;
    end else begin
      tone_q  <= tone_next;
      place_q <= fold_place(reg_place);
    end
  end

  assign tone_o  = tone_q;
  assign place_o = place_q;

  // R6: a closed gate silences the external source
  a_r6_gate_closed_silent: assert property (@(posedge clk) disable iff (rst)
    (reg_host_en && !reg_src_int && !reg_gate) |=> !tone_o);

  // R9: the unused placement code folds to the default
  a_r9_place_fold: assert property (@(posedge clk) disable iff (rst)
    (reg_place == 2'b11) |=> (place_o == 2'b00));

  // R1: reset forces quiet outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tone_o && place_o == 2'b00));
endmodule

// File: tb/tone_gate_ctrl_bench.sv
`timescale 1ns/1ps
module tone_gate_ctrl_bench;
  localparam int CLK_HZ = 440_000;
  localparam int TONE_HZ = 22_000;
  localparam int H = CLK_HZ / (2 * TONE_HZ); // 10
  localparam int WIN = 44;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extm = 1'b0;
  logic host_en = 1'b0, src_int = 1'b0, gate = 1'b0;
  logic [1:0] place = 2'b00;
  logic tone;
  logic [1:0] place_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tone_gate_ctrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .WINDOW_US(100), .SYNC_STAGES(2))
    u_tone_gate_ctrl (
      .clk(clk), .rst(rst), .extm_i(extm), .reg_host_en(host_en),
      .reg_src_int(src_int), .reg_gate(gate), .reg_place(place),
      .tone_o(tone), .place_o(place_out));

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Starts the generator through reg_gate; returns after sample k=0
  task automatic start_internal();
    gate = 1'b1;
    tick(2);
  endtask

  task automatic t_reset();
    place = 2'b10;
    gate = 1'b1; host_en = 1'b1;
    tick(3);
    check("R1 tone in reset", tone, 0);
    check("R1 place in reset", place_out, 0);
    rst = 1'b0;
    check("R1 tone after reset", tone, 0);
    check("R1 place after reset", place_out, 0);
    gate = 1'b0; host_en = 1'b0; place = 2'b00;
    tick(60);
  endtask

  task automatic t_place();
    logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    logic [1:0] exp   [4] = '{2'b00, 2'b01, 2'b10, 2'b00};
    for (int i = 0; i < 4; i++) begin
      place = codes[i];
      tick(1);
      check("R9 placement code", place_out, exp[i]);
    end
    place = 2'b00;
  endtask

  task automatic t_internal_wave();
    host_en = 1'b1; src_int = 1'b1; extm = 1'b0;
    tick(5);
    start_internal();
    for (int k = 0; k < 4 * H; k++) begin
      check("R2/R7 internal wave", tone, ((k / H) % 2 == 0) ? 1 : 0);
      tick(1);
    end
    gate = 1'b0;
    tick(3 * H);
    check("R7 gate off quiet", tone, 0);
  endtask

  task automatic t_finish_half();
    start_internal();
    for (int k = 0; k < 3 * H; k++) begin
      check("R3 finish current half", tone, (k < H) ? 1 : 0);
      if (k == 2) gate = 1'b0;
      tick(1);
    end
  endtask

  task automatic t_restart();
    start_internal();
    for (int k = 0; k < H + 5; k++) begin
      if (k == H + 4) gate = 1'b0;
      tick(1);
    end
    tick(2 * H);
    start_internal();
    check("R3 restart high", tone, 1);
    tick(H - 1);
    check("R3 restart full high half", tone, 1);
    tick(1);
    check("R3 restart then low", tone, 0);
    gate = 1'b0;
    tick(3 * H);
  endtask

  // Gate falls on the same edge where the high half ends
  task automatic t_coincide();
    start_internal();
    for (int k = 0; k < 3 * H; k++) begin
      check("R3 coincident stop", tone, (k < H) ? 1 : 0);
      if (k == H - 2) gate = 1'b0;
      tick(1);
    end
  endtask

  task automatic t_env_stop_high();
    host_en = 1'b1; src_int = 1'b1; gate = 1'b0; extm = 1'b1;
    tick(6);
    start_internal();
    for (int k = 0; k < 5 * H; k++) begin
      int e;
      e = (k < H) ? 1 : (k < 2 * H) ? 0 : (k < 3 * H) ? 1 : 0;
      check("R8 envelope ends high", tone, e);
      if (k == H + 2) extm = 1'b0;
      tick(1);
    end
    gate = 1'b0;
    tick(3 * H);
  endtask

  task automatic t_ext_gated();
    host_en = 1'b1; src_int = 1'b0; gate = 1'b0;
    tick(1);
    check("R10 control latency", tone, 0);
    for (int i = 0; i < 4; i++) begin
      extm = i[0] ? 1'b0 : 1'b1;
      tick(4);
      check("R6 gate closed", tone, 0);
      tick(2);
    end
    gate = 1'b1;
    for (int i = 0; i < 4; i++) begin
      extm = i[0] ? 1'b0 : 1'b1;
      tick(2);
      check("R10 pin latency before", tone, i[0] ? 1 : 0);
      tick(1);
      check("R6 gate open follows pin", tone, i[0] ? 0 : 1);
      tick(3);
    end
    extm = 1'b1;
    tick(4);
    gate = 1'b0;
    tick(1);
    check("R10 gate one cycle", tone, 0);
    extm = 1'b0;
    tick(WIN + 20);
  endtask

  task automatic t_pin_burst();
    host_en = 1'b0; src_int = 1'b0; gate = 1'b0; extm = 1'b0;
    tick(WIN + 10);
    for (int i = 0; i < 8; i++) begin
      extm = i[0] ? 1'b0 : 1'b1;
      tick(4);
      check("R4 burst passthrough", tone, i[0] ? 0 : 1);
      tick(2);
    end
    extm = 1'b0;
    tick(WIN + 20);
  endtask

  task automatic t_pin_envelope();
    int trans;
    logic last;
    host_en = 1'b0; extm = 1'b1;
    tick(WIN + 20);
    trans = 0;
    last = tone;
    for (int k = 0; k < 4 * H; k++) begin
      tick(1);
      if (tone != last) trans++;
      last = tone;
    end
    check("R5 envelope runs internal wave", (trans >= 3) ? 1 : 0, 1);
    extm = 1'b0;
    tick(5);
    check("R5 envelope ended low", tone, 0);
    tick(WIN + 20);
    check("R5 pin low stays quiet", tone, 0);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_place();
    t_internal_wave();
    t_finish_half();
    t_restart();
    t_coincide();
    t_env_stop_high();
    t_ext_gated();
    t_pin_burst();
    t_pin_envelope();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule